// File: doc/BRIEF.md
# Descriptor-Driven I2C Transfer Sequencer

This block runs I2C transfers from a small table of transmit and receive descriptors held in local registers. Software fills in the descriptors through a simple host port and pulses `go`. The sequencer then walks the transmit table from entry 0. For each ready entry it issues byte-level commands to an external I2C byte master: a START, the address byte, then data writes or data reads. Completion and error flags are written back into each descriptor, and a one-cycle event is raised for each of them.

Each transmit descriptor has a 16-bit control/status word, a 16-bit length and an 8-byte buffer. The length counts the address byte plus the payload. Byte 0 holds the 7-bit target address shifted left by one, and its bit 0 is 1 for a read. For a read, only the address byte is driven. Each remaining byte slot issues one READ command, and the returned bytes go into the next receive descriptor in its own table.

The byte master sees one command at a time. The block holds `cmd_valid` and the command fields until the master returns a one-cycle `rsp_valid`, together with the ack and arbitration result.

Top module: `i2c_bd_seq`

## Requirements
- R1: Control-word bits (all other bits are unused): bit 15 is READY (transmit) or EMPTY (receive); bit 13 is WRAP; bit 11 is LAST; bit 10 is START; bit 2 is NAK; bit 1 is UNDERRUN; bit 0 is COLLISION (transmit) or OVERRUN (receive). Host field select: 0 is the control word, 1 is the length, and 2+k is buffer byte k. Command codes: 0 START, 1 WRITE, 2 READ, 3 STOP.
- R2: A ready transmit descriptor of length L sends buffer byte 0 as a WRITE, then L-1 payload slots. For a write (byte 0 bit 0 = 0), the slots are WRITEs of buffer bytes 1 to L-1.
- R3: If START is set, a START command (or repeated START) comes before the address byte. If START is clear, the address byte follows the previous byte with no START in between.
- R4: When a descriptor completes, its READY bit is cleared and `ev_txb` pulses. If LAST is set, a STOP command follows, and `busy` falls once the STOP has been acknowledged.
- R5: After a descriptor, the table pointer returns to entry 0 if WRAP is set or the entry is the last one; otherwise it moves to the next entry. Meeting an entry that is not ready ends the transfer, with a STOP if the bus is held.
- R6: For a read, each payload slot issues a READ. The master is told to ack every byte except the last. Returned bytes are stored in order in the paired receive descriptor. That descriptor's EMPTY bit is cleared, its length is set to the number of bytes read, and `ev_rxb` pulses.
- R7: A nack to a written byte sets NAK in the transmit descriptor, pulses `ev_err`, and clears READY. The sequencer then issues STOP and leaves later descriptors untouched.
- R8: Loss of arbitration on any command except STOP sets COLLISION, and the transfer is aborted as in R7.
- R9: A write that runs past the 8 stored bytes, or a descriptor of length 0, sets UNDERRUN and aborts the transfer.
- R10: A read of 513 or more payload bytes is rejected before any bus command. OVERRUN is set on the receive descriptor, EMPTY is left set, and `ev_err` pulses. An accepted read longer than the buffer still clocks every byte, keeps only the first 8, and sets OVERRUN.
- R11: `go` sends both table pointers back to entry 0. `busy` is high from `go` until the transfer ends, and no command is issued while `busy` is low.
- R12: A command and its fields stay unchanged while `cmd_valid` is high and no response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start command pulse |
| h_we | input | 1 | Host write strobe (accepted while idle) |
| h_rx | input | 1 | Host selects receive table (1) or transmit table (0) |
| h_idx | input | 2 | Host descriptor index |
| h_fld | input | 4 | Host field select |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data for the selected field |
| cmd_valid | output | 1 | Command request to byte master |
| cmd_op | output | 2 | Command code |
| cmd_data | output | 8 | Byte to write |
| cmd_ack | output | 1 | Ack the byte being read |
| rsp_valid | input | 1 | Command done, one cycle |
| rsp_data | input | 8 | Byte read |
| rsp_nak | input | 1 | Target did not ack the written byte |
| rsp_lost | input | 1 | Arbitration was lost |
| busy | output | 1 | Transfer in progress |
| ev_txb | output | 1 | Transmit descriptor complete |
| ev_rxb | output | 1 | Receive descriptor filled |
| ev_err | output | 1 | Descriptor aborted with an error |

## Verification
The assertions check the handshake and sequencing rules on every cycle. A pending command must not change before its response arrives. Commands appear only while `busy` is high. An acknowledged STOP always drops `busy`, and `go` always raises it. A read completion always coincides with a transmit completion, and never with an error event. Only the bench scenarios can show the order of commands on the bus, the flags written back into each descriptor, the stored read bytes, wrap and pointer restart, and the 512/513-byte read limit.

// File: rtl/i2c_bd_seq.sv
`timescale 1ns/1ps
module i2c_bd_seq #(
  parameter int NBD   = 4,
  parameter int BUFB  = 8,
  parameter int MAXRD = 513,
  localparam int IW = $clog2(NBD),
  localparam int FW = $clog2(BUFB + 2),
  localparam int BW = $clog2(BUFB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          h_we,
  input  logic          h_rx,
  input  logic [IW-1:0] h_idx,
  input  logic [FW-1:0] h_fld,
  input  logic [15:0]   h_wdata,
  output logic [15:0]   h_rdata,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_data,
  output logic          cmd_ack,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_data,
  input  logic          rsp_nak,
  input  logic          rsp_lost,
  output logic          busy,
  output logic          ev_txb,
  output logic          ev_rxb,
  output logic          ev_err
);
  localparam int RDY = 15, WRP = 13, LST = 11, STA = 10, NAK = 2, UND = 1, CLO = 0;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_START, S_ADDR, S_DATA, S_STOP} st_t;
  st_t state;

  logic [15:0] tx_sc [NBD];
  logic [15:0] tx_len[NBD];
  logic [15:0] rx_sc [NBD];
  logic [15:0] rx_len[NBD];
  logic [7:0]  tx_buf[NBD][BUFB];
  logic [7:0]  rx_buf[NBD][BUFB];
  logic [IW-1:0] tp, rp;
  logic [15:0] idx, n, cnt;
  logic rd, open;

  logic [15:0] cur_sc, cur_len;
  logic [BW-1:0] bsel;
  logic fld_buf, rd_cur, wr_short, resp, err_lost, err_nak, err_un, err_big, abort, step, fin;
  logic [IW-1:0] tp_nx, rp_nx;

  assign cur_sc  = tx_sc[tp];
  assign cur_len = tx_len[tp];
  assign rd_cur  = tx_buf[tp][0][0];
  assign bsel    = BW'(h_fld - FW'(2));
  assign fld_buf = h_fld >= FW'(2) && h_fld < FW'(BUFB + 2);

  always_comb begin
    h_rdata = 16'h0;
    if (h_fld == FW'(0))      h_rdata = h_rx ? rx_sc[h_idx]  : tx_sc[h_idx];
    else if (h_fld == FW'(1)) h_rdata = h_rx ? rx_len[h_idx] : tx_len[h_idx];
    else if (fld_buf)         h_rdata = {8'h00, h_rx ? rx_buf[h_idx][bsel] : tx_buf[h_idx][bsel]};
  end

  assign wr_short  = state == S_DATA && !rd && idx >= 16'(BUFB);
  assign cmd_valid = state == S_START || state == S_ADDR || state == S_STOP ||
                     (state == S_DATA && !wr_short);
  always_comb begin
    case (state)
      S_START: cmd_op = 2'd0;
      S_DATA:  cmd_op = rd ? 2'd2 : 2'd1;
      S_STOP:  cmd_op = 2'd3;
      default: cmd_op = 2'd1;
    endcase
  end
  assign cmd_data = state == S_ADDR ? tx_buf[tp][0] :
                    (state == S_DATA && !rd && !wr_short) ? tx_buf[tp][idx[BW-1:0]] : 8'h00;
  assign cmd_ack  = state == S_DATA && rd && idx != n;

  assign resp     = cmd_valid && rsp_valid;
  assign err_lost = resp && rsp_lost && state != S_STOP;
  assign err_nak  = resp && !rsp_lost && rsp_nak && (state == S_ADDR || (state == S_DATA && !rd));
  assign err_un   = wr_short || (state == S_FETCH && cur_sc[RDY] && cur_len == 16'd0);
  assign err_big  = state == S_FETCH && cur_sc[RDY] && cur_len != 16'd0 && rd_cur &&
                    (cur_len - 16'd1) >= 16'(MAXRD);
  assign abort    = err_lost || err_nak || err_un || err_big;
  assign step     = resp && !err_lost && !err_nak && (state == S_ADDR || state == S_DATA);
  assign fin      = step && (state == S_ADDR ? n == 16'd0 : idx == n);
  assign tp_nx    = (cur_sc[WRP] || tp == IW'(NBD - 1)) ? '0 : tp + IW'(1);
  assign rp_nx    = (rx_sc[rp][WRP] || rp == IW'(NBD - 1)) ? '0 : rp + IW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tp <= '0; rp <= '0; idx <= '0; n <= '0; cnt <= '0;
      rd <= 1'b0; open <= 1'b0; busy <= 1'b0;
      ev_txb <= 1'b0; ev_rxb <= 1'b0; ev_err <= 1'b0;
      for (int i = 0; i < NBD; i++) begin
        tx_sc[i] <= '0; tx_len[i] <= '0; rx_sc[i] <= '0; rx_len[i] <= '0;
        for (int j = 0; j < BUFB; j++) begin
          tx_buf[i][j] <= '0; rx_buf[i][j] <= '0;
        end
      end
    end else begin
      ev_txb <= 1'b0; ev_rxb <= 1'b0; ev_err <= 1'b0;
      if (h_we && !busy) begin
        if (h_fld == FW'(0)) begin
          if (h_rx) rx_sc[h_idx] <= h_wdata; else tx_sc[h_idx] <= h_wdata;
        end else if (h_fld == FW'(1)) begin
          if (h_rx) rx_len[h_idx] <= h_wdata; else tx_len[h_idx] <= h_wdata;
        end else if (fld_buf) begin
          if (h_rx) rx_buf[h_idx][bsel] <= h_wdata[7:0]; else tx_buf[h_idx][bsel] <= h_wdata[7:0];
        end
      end
      case (state)
        S_IDLE: if (go) begin
          tp <= '0; rp <= '0; busy <= 1'b1; state <= S_FETCH;
        end
        S_FETCH:
          if (!cur_sc[RDY]) begin
            state <= open ? S_STOP : S_IDLE;
            if (!open) busy <= 1'b0;
          end else if (!err_un && !err_big) begin
            rd <= rd_cur; n <= cur_len - 16'd1; idx <= 16'd1; cnt <= '0;
            state <= cur_sc[STA] ? S_START : S_ADDR;
          end
        S_START: if (resp) begin
          open <= 1'b1;
          if (!rsp_lost) state <= S_ADDR;
        end
        S_STOP: if (resp) begin
          open <= 1'b0; busy <= 1'b0; state <= S_IDLE;
        end
        default: ;
      endcase
      if (step && state == S_DATA && rd) begin
        if (cnt < 16'(BUFB)) rx_buf[rp][cnt[BW-1:0]] <= rsp_data;
        else rx_sc[rp][CLO] <= 1'b1;
        cnt <= cnt + 16'd1;
      end
      if (step && !fin) begin
        if (state == S_ADDR) state <= S_DATA;
        else idx <= idx + 16'd1;
      end
      if (fin) begin
        tx_sc[tp][RDY] <= 1'b0; ev_txb <= 1'b1; tp <= tp_nx;
        if (rd) begin
          rx_sc[rp][RDY] <= 1'b0; ev_rxb <= 1'b1; rp <= rp_nx;
          rx_len[rp] <= state == S_DATA ? cnt + 16'd1 : cnt;
        end
        state <= cur_sc[LST] ? S_STOP : S_FETCH;
      end
      if (abort) begin
        tx_sc[tp][RDY] <= 1'b0; ev_err <= 1'b1;
        if (err_lost) tx_sc[tp][CLO] <= 1'b1;
        if (err_nak)  tx_sc[tp][NAK] <= 1'b1;
        if (err_un)   tx_sc[tp][UND] <= 1'b1;
        if (err_big)  rx_sc[rp][CLO] <= 1'b1;
        if (open || state == S_START) state <= S_STOP;
        else begin state <= S_IDLE; busy <= 1'b0; end
      end
    end
  end
endmodule

// File: rtl/i2c_bd_seq_chk.sv
`timescale 1ns/1ps
module i2c_bd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       cmd_ack,
  input logic       rsp_valid,
  input logic       busy,
  input logic       ev_txb,
  input logic       ev_rxb,
  input logic       ev_err
);
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !rsp_valid |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data) && $stable(cmd_ack));
  p_cmd_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
  p_go_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && go |=> busy);
  p_stop_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && rsp_valid && cmd_op == 2'd3 |=> !busy);
  p_rx_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxb |-> ev_txb);
  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> !ev_txb);
endmodule

bind i2c_bd_seq i2c_bd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_data(cmd_data), .cmd_ack(cmd_ack), .rsp_valid(rsp_valid), .busy(busy),
  .ev_txb(ev_txb), .ev_rxb(ev_rxb), .ev_err(ev_err));

// File: tb/tb_i2c_bd_seq.sv
`timescale 1ns/1ps
module tb_i2c_bd_seq;
  logic clk = 0, rst_n = 0, go = 0;
  logic h_we = 0, h_rx = 0;
  logic [1:0] h_idx = 0;
  logic [3:0] h_fld = 0;
  logic [15:0] h_wdata = 0, h_rdata;
  logic cmd_valid, cmd_ack, busy, ev_txb, ev_rxb, ev_err;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic rsp_valid = 0, rsp_nak = 0, rsp_lost = 0;
  logic [7:0] rsp_data = 0;

  i2c_bd_seq dut (.*);

  always #2.5 clk = ~clk;

  int nt = 0, nf = 0, ncmd = 0, nak_at = -1, lost_at = -1;
  int c_txb = 0, c_rxb = 0, c_err = 0;
  logic [10:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nt++;
    if (act !== exp) begin
      nf++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] norm(input logic [1:0] op, input logic [7:0] d, input logic a);
    return {a & (op == 2'd2), op, (op == 2'd1) ? d : 8'h00};
  endfunction

  task automatic ex(input logic [1:0] op, input logic [7:0] d = 0, input logic a = 0);
    exp_q.push_back(norm(op, d, a));
  endtask

  // byte master model and scoreboard monitor
  always @(negedge clk) begin
    if (rsp_valid) begin
      rsp_valid = 0; rsp_nak = 0; rsp_lost = 0;
    end else if (cmd_valid && rst_n) begin
      nt++;
      if (exp_q.size() == 0) begin
        nf++;
        $display("FAIL R2: actual unexpected command %0h expected none", norm(cmd_op, cmd_data, cmd_ack));
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        if (norm(cmd_op, cmd_data, cmd_ack) !== e) begin
          nf++;
          $display("FAIL R2/R3/R6 cmd %0d: actual %0h expected %0h", ncmd, norm(cmd_op, cmd_data, cmd_ack), e);
        end
      end
      rsp_nak  = (ncmd == nak_at);
      rsp_lost = (ncmd == lost_at);
      rsp_data = 8'hC0 ^ 8'(ncmd);
      rsp_valid = 1;
      ncmd++;
    end
  end

  always @(posedge clk) begin
    if (ev_txb) c_txb++;
    if (ev_rxb) c_rxb++;
    if (ev_err) c_err++;
  end

  task automatic hw(input bit rx, input int i, input int f, input logic [15:0] v);
    @(negedge clk);
    h_we = 1; h_rx = rx; h_idx = 2'(i); h_fld = 4'(f); h_wdata = v;
    @(negedge clk);
    h_we = 0;
  endtask

  task automatic hr(input bit rx, input int i, input int f, output logic [15:0] v);
    h_rx = rx; h_idx = 2'(i); h_fld = 4'(f);
    #1 v = h_rdata;
  endtask

  task automatic txd(input int i, input logic [15:0] sc, input logic [15:0] len,
                     input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    hw(0, i, 1, len); hw(0, i, 2, {8'h0, b0}); hw(0, i, 3, {8'h0, b1}); hw(0, i, 4, {8'h0, b2});
    hw(0, i, 0, sc);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) begin hw(0, i, 0, 0); hw(1, i, 0, 0); end
  endtask

  task automatic run(input int nk, input int lt);
    nak_at = nk; lost_at = lt; ncmd = 0; c_txb = 0; c_rxb = 0; c_err = 0;
    @(negedge clk) go = 1;
    @(negedge clk) go = 0;
    chk("R11 busy after go", busy, 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R2 all expected commands seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nf++; nt++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R12 reset cmd_valid", cmd_valid, 0);
    hr(0, 0, 0, v); chk("R1 reset tx0 sc", v, 16'h0);

    // plain write with START and LAST
    txd(0, 16'h8C00, 3, 8'hA0, 8'h5A, 8'h3C);
    ex(0); ex(1, 8'hA0); ex(1, 8'h5A); ex(1, 8'h3C); ex(3);
    run(-1, -1);
    hr(0, 0, 0, v); chk("R4 ready cleared", v, 16'h0C00);
    chk("R4 ev_txb count", c_txb, 1);

    // write, then read with repeated START
    clear_all();
    txd(0, 16'h8400, 2, 8'hA0, 8'h77, 8'h00);
    txd(1, 16'h8C00, 4, 8'hA1, 8'h00, 8'h00);
    hw(1, 0, 0, 16'h8000);
    ex(0); ex(1, 8'hA0); ex(1, 8'h77); ex(0); ex(1, 8'hA1);
    ex(2, 0, 1); ex(2, 0, 1); ex(2, 0, 0); ex(3);
    run(-1, -1);
    hr(1, 0, 0, v); chk("R6 rx EMPTY cleared", v, 16'h0000);
    hr(1, 0, 1, v); chk("R6 rx length", v, 3);
    hr(1, 0, 2, v); chk("R6 rx byte0", v, 16'h00C5);
    hr(1, 0, 4, v); chk("R6 rx byte2", v, 16'h00C7);
    chk("R6 ev_rxb count", c_rxb, 1);
    chk("R4 ev_txb count two", c_txb, 2);

    // continuation without START
    clear_all();
    txd(0, 16'h8400, 2, 8'hA0, 8'h01, 8'h00);
    txd(1, 16'h8800, 2, 8'h02, 8'h03, 8'h00);
    ex(0); ex(1, 8'hA0); ex(1, 8'h01); ex(1, 8'h02); ex(1, 8'h03); ex(3);
    run(-1, -1);
    hr(0, 1, 0, v); chk("R3 no-start desc done", v, 16'h0800);

    // nak on address; pointer restarts at entry 0 (R11)
    clear_all();
    txd(0, 16'h8400, 2, 8'hA0, 8'h01, 8'h00);
    txd(1, 16'h8C00, 2, 8'hA2, 8'h02, 8'h00);
    ex(0); ex(1, 8'hA0); ex(3);
    run(1, -1);
    hr(0, 0, 0, v); chk("R7 NAK flag", v, 16'h0404);
    hr(0, 1, 0, v); chk("R7 later desc untouched", v, 16'h8C00);
    chk("R7 ev_err", c_err, 1);

    // arbitration lost on data byte
    clear_all();
    txd(0, 16'h8C00, 3, 8'hA0, 8'h11, 8'h22);
    ex(0); ex(1, 8'hA0); ex(1, 8'h11); ex(3);
    run(-1, 2);
    hr(0, 0, 0, v); chk("R8 COLLISION flag", v, 16'h0C01);

    // underrun: length 10, only 8 bytes stored
    clear_all();
    txd(0, 16'h8C00, 10, 8'hA0, 8'h11, 8'h22);
    for (int k = 3; k < 8; k++) hw(0, 0, 2 + k, 16'(k * 17));
    ex(0); ex(1, 8'hA0);
    for (int k = 1; k < 8; k++) ex(1, 8'(k * 17));
    ex(3);
    run(-1, -1);
    hr(0, 0, 0, v); chk("R9 UNDERRUN flag", v, 16'h0C02);
    chk("R9 ev_err", c_err, 1);

    // read of 513 payload bytes rejected
    clear_all();
    txd(0, 16'h8C00, 514, 8'hA1, 8'h00, 8'h00);
    hw(1, 0, 0, 16'h8000);
    run(-1, -1);
    hr(1, 0, 0, v); chk("R10 reject: OVERRUN, EMPTY kept", v, 16'h8001);
    chk("R10 reject ev_err", c_err, 1);

    // read of 512 accepted, overflows local buffer
    clear_all();
    hw(1, 0, 1, 0);
    txd(0, 16'h8C00, 513, 8'hA1, 8'h00, 8'h00);
    hw(1, 0, 0, 16'h8000);
    ex(0); ex(1, 8'hA1);
    for (int k = 0; k < 512; k++) ex(2, 0, k != 511);
    ex(3);
    run(-1, -1);
    hr(1, 0, 0, v); chk("R10 512 read: OVERRUN, EMPTY cleared", v, 16'h0001);
    hr(1, 0, 1, v); chk("R10 512 read length", v, 512);
    hr(1, 0, 9, v); chk("R10 byte7 kept", v, 16'h00C9);

    // wrap at entry 1 back to not-ready entry 0
    clear_all();
    txd(0, 16'h8400, 2, 8'hA0, 8'h01, 8'h00);
    txd(1, 16'hA400, 2, 8'hA2, 8'h02, 8'h00);
    txd(2, 16'h8C00, 2, 8'hA4, 8'h04, 8'h00);
    ex(0); ex(1, 8'hA0); ex(1, 8'h01); ex(0); ex(1, 8'hA2); ex(1, 8'h02); ex(3);
    run(-1, -1);
    hr(0, 2, 0, v); chk("R5 entry after wrap unused", v, 16'h8C00);
    chk("R5 two completions", c_txb, 2);

    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule